// File: doc/BRIEF.md
# Interrupt and Return Stack Sequencer

This block takes the stack memory traffic of interrupt entry, subroutine call, interrupt return and subroutine return off a small 8-bit processor core. It keeps the stack pointer. For each stack access it builds the full address from a high byte and the pointer. The high byte is picked by a page-select input. A single byte-wide memory port carries the accesses, and the block uses one access per clock cycle.

The core gives a one-cycle start with an operation code and the values to save: program counter, status byte and a break indication. The sequencer captures these at acceptance. It then writes the bytes while the pointer counts down, or reads them back while the pointer counts up.

On an entry, the pushed status carries a break bit that tells a software break apart from a hardware interrupt. The live status output gets its interrupt-disable bit set at once. On a return, the restored program counter and status appear on the outputs. A one-cycle done pulse closes every sequence.

Top module: `stack_sequencer`

## Requirements
- R1: After reset the pointer reads 0xFF, the status output is 0x04 (only the interrupt-disable bit, bit 2, set), the program counter output is 0, and done, write enable and read enable are all low.
- R2: Interrupt entry (op code 0) writes three bytes in this order: program counter bits 15:8, then bits 7:0, then the status byte. Each write uses the current pointer as address bits 7:0, and the pointer drops by one after each write.
- R3: A subroutine call (op code 1) writes only the two program counter bytes, upper byte first. The pointer ends two lower, and the status output is left unchanged.
- R4: Interrupt return (op code 2) reads at pointer+1 three times, and the pointer moves up after each read. The first byte read becomes the status output, the second becomes program counter bits 7:0 and the third becomes bits 15:8.
- R5: Subroutine return (op code 3) reads two bytes at pointer+1. The first becomes program counter bits 7:0 and the second becomes bits 15:8. The status output is left unchanged.
- R6: Address bits 15:8 of every access are 0x00 when page select was 0 at acceptance and 0x01 when it was 1. Values placed on the inputs after acceptance have no effect on the sequence.
- R7: On interrupt entry, the pushed status byte equals the status input with bit 4 replaced by the break input: 1 for a software break, 0 for a hardware interrupt.
- R8: On interrupt entry, the status output equals the status input with bit 2 set, from the first cycle after acceptance onwards.
- R9: Accesses occupy consecutive cycles, one per cycle, starting the cycle after acceptance. Done is high for exactly one cycle, the cycle after the last access, with no access in that cycle.
- R10: The pointer wraps modulo 256 inside the selected page, in both directions, with no overflow indication.
- R11: A start request while a sequence is in progress is ignored. It produces no extra access and no change to the running sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| op_i | input | 2 | Operation: 0 interrupt entry, 1 call, 2 interrupt return, 3 subroutine return |
| brk_i | input | 1 | Entry caused by a software break |
| page_sel_i | input | 1 | Selects stack page high byte (0x00 or 0x01) |
| pc_i | input | 16 | Program counter to save |
| status_i | input | 8 | Status byte to save |
| mem_rdata_i | input | 8 | Memory read data, valid in the cycle the read address is presented |
| mem_addr_o | output | 16 | Stack access address |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Write enable |
| mem_re_o | output | 1 | Read enable |
| sp_o | output | 8 | Current stack pointer |
| pc_o | output | 16 | Restored program counter |
| status_o | output | 8 | Current status byte |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Take the rising edge that samples start as edge 0. Access k of an N-access sequence then sits in the cycle after edge k. Done, the final pointer and the restored program counter and status all appear in the cycle after edge N. The entry status with bit 2 set is already visible in the cycle after edge 0.

The bench drives its inputs on falling edges. It counts falling edges from acceptance and expects done at exactly N+1. Every access seen at a falling edge is matched in order against a queue of expected addresses and write bytes. The queue is filled before the start is driven, and it must be empty once done has been seen.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

   // Operation codes carried on op_i
   typedef enum logic [1:0] {
      OP_INT_ENTRY  = 2'b00,
      OP_CALL       = 2'b01,
      OP_INT_RETURN = 2'b10,
      OP_SUB_RETURN = 2'b11
   } stk_op_e;

   // Entry and call write to the stack; both returns read from it.
   function automatic logic op_is_push(input stk_op_e op);
      return (op == OP_INT_ENTRY) || (op == OP_CALL);
   endfunction

   // Only the interrupt pair moves the status byte.
   function automatic logic op_has_status(input stk_op_e op);
      return (op == OP_INT_ENTRY) || (op == OP_INT_RETURN);
   endfunction

endpackage

// File: rtl/stkseq_ptr.sv
module stkseq_ptr #(
   parameter int               PTR_W  = 8,
   parameter logic [PTR_W-1:0] SP_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_stb_i,
   input  logic             pop_stb_i,
   output logic [PTR_W-1:0] sp_o,
   output logic [PTR_W-1:0] sp_up_o
);

   logic [PTR_W-1:0] sp_q;

   // Pre-incremented value: read address and next pointer on a pop
   assign sp_up_o = sp_q + PTR_W'(1);
   assign sp_o    = sp_q;

   // Post-decrement on push, pre-increment on pop, natural wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q <= SP_RST;
      end else if (push_stb_i) begin
         sp_q <= sp_q - PTR_W'(1);
      end else if (pop_stb_i) begin
         sp_q <= sp_up_o;
      end
   end

endmodule

// File: rtl/stkseq_ctrl.sv
module stkseq_ctrl
   import stkseq_pkg::*;
#(
   parameter int PC_BYTES = 2,
   parameter int STEP_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  stk_op_e           op_i,
   output logic              accept_o,
   output stk_op_e           op_o,
   output logic [STEP_W-1:0] step_o,
   output logic              push_stb_o,
   output logic              pop_stb_o,
   output logic              done_o
);

   localparam logic [STEP_W-1:0] LAST_PC_ONLY = STEP_W'(PC_BYTES - 1);
   localparam logic [STEP_W-1:0] LAST_WITH_ST = STEP_W'(PC_BYTES);

   logic              busy_q;
   logic              done_q;
   stk_op_e           op_q;
   logic [STEP_W-1:0] step_q;
   logic [STEP_W-1:0] last_step;
   logic              at_last;

   // A request is taken only while no sequence runs
   assign accept_o  = start_i && !busy_q;
   assign last_step = op_has_status(op_q) ? LAST_WITH_ST : LAST_PC_ONLY;
   assign at_last   = busy_q && (step_q == last_step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         op_q   <= OP_INT_ENTRY;
         step_q <= '0;
      end else begin
         done_q <= at_last;
         if (accept_o) begin
            busy_q <= 1'b1;
            op_q   <= op_i;
            step_q <= '0;
         end else if (at_last) begin
            busy_q <= 1'b0;
            step_q <= '0;
         end else if (busy_q) begin
            step_q <= step_q + STEP_W'(1);
         end
      end
   end

   assign op_o       = op_q;
   assign step_o     = step_q;
   assign push_stb_o = busy_q && op_is_push(op_q);
   assign pop_stb_o  = busy_q && !op_is_push(op_q);
   assign done_o     = done_q;

endmodule

// File: rtl/stkseq_data.sv
module stkseq_data
   import stkseq_pkg::*;
#(
   parameter int                DATA_W      = 8,
   parameter int                PC_W        = 16,
   parameter int                PAGE_W      = 8,
   parameter int                STEP_W      = 2,
   parameter int                BRK_BIT     = 4,
   parameter int                IDIS_BIT    = 2,
   parameter bit                PAGE_SEL_EN = 1'b1,
   parameter logic [PAGE_W-1:0] PAGE0_HI    = 8'h00,
   parameter logic [PAGE_W-1:0] PAGE1_HI    = 8'h01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  stk_op_e           op_acc_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [DATA_W-1:0] status_i,
   input  logic              brk_i,
   input  logic              page_sel_i,
   input  stk_op_e           op_q_i,
   input  logic [STEP_W-1:0] step_i,
   input  logic              pop_stb_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [DATA_W-1:0] wdata_o,
   output logic [PAGE_W-1:0] page_hi_o,
   output logic [PC_W-1:0]   pc_o,
   output logic [DATA_W-1:0] status_o
);

   localparam int                PC_BYTES  = PC_W / DATA_W;
   localparam logic [DATA_W-1:0] IDIS_MASK = DATA_W'(1) << IDIS_BIT;

   logic [PC_W-1:0]   pc_lat;
   logic [DATA_W-1:0] st_lat;
   logic [DATA_W-1:0] st_push;
   logic [DATA_W-1:0] status_q;
   logic              stat_step;
   int                pop_idx;

   // Break bit of the saved status follows the cause of entry
   always_comb begin
      st_push          = status_i;
      st_push[BRK_BIT] = brk_i;
   end

   // Capture everything at acceptance so later input changes do not matter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_lat <= '0;
         st_lat <= '0;
      end else if (accept_i) begin
         pc_lat <= pc_i;
         st_lat <= st_push;
      end
   end

   // Push order: most significant PC byte first, status last
   always_comb begin
      wdata_o = st_lat;
      for (int b = 0; b < PC_BYTES; b++) begin
         if (int'(step_i) == PC_BYTES - 1 - b) begin
            wdata_o = pc_lat[b*DATA_W +: DATA_W];
         end
      end
   end

   // Pop order: status first (when present), then PC bytes from least significant
   always_comb begin
      stat_step = op_has_status(op_q_i) && (step_i == '0);
      pop_idx   = int'(step_i) - (op_has_status(op_q_i) ? 1 : 0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= IDIS_MASK;
      end else if (accept_i && (op_acc_i == OP_INT_ENTRY)) begin
         status_q <= status_i | IDIS_MASK;
      end else if (pop_stb_i && stat_step) begin
         status_q <= rdata_i;
      end
   end
   assign status_o = status_q;

   for (genvar g = 0; g < PC_BYTES; g++) begin : g_pc_byte
      logic [DATA_W-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (pop_stb_i && !stat_step && (pop_idx == g)) begin
            byte_q <= rdata_i;
         end
      end
      assign pc_o[g*DATA_W +: DATA_W] = byte_q;
   end

   // Page high byte: selectable or fixed variant
   if (PAGE_SEL_EN) begin : g_page_sel
      logic page_lat;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            page_lat <= 1'b0;
         end else if (accept_i) begin
            page_lat <= page_sel_i;
         end
      end
      assign page_hi_o = page_lat ? PAGE1_HI : PAGE0_HI;
   end else begin : g_page_fixed
      logic unused_page_sel;
      assign unused_page_sel = page_sel_i;
      assign page_hi_o       = PAGE0_HI;
   end

endmodule

// File: rtl/stack_sequencer.sv
module stack_sequencer
   import stkseq_pkg::*;
#(
   parameter int                DATA_W      = 8,
   parameter int                PTR_W       = 8,
   parameter int                PAGE_W      = 8,
   parameter int                PC_W        = 16,
   parameter int                BRK_BIT     = 4,
   parameter int                IDIS_BIT    = 2,
   parameter bit                PAGE_SEL_EN = 1'b1,
   parameter logic [PAGE_W-1:0] PAGE0_HI    = 8'h00,
   parameter logic [PAGE_W-1:0] PAGE1_HI    = 8'h01,
   parameter logic [PTR_W-1:0]  SP_RST      = '1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [1:0]              op_i,
   input  logic                    brk_i,
   input  logic                    page_sel_i,
   input  logic [PC_W-1:0]         pc_i,
   input  logic [DATA_W-1:0]       status_i,
   input  logic [DATA_W-1:0]       mem_rdata_i,
   output logic [PAGE_W+PTR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0]       mem_wdata_o,
   output logic                    mem_we_o,
   output logic                    mem_re_o,
   output logic [PTR_W-1:0]        sp_o,
   output logic [PC_W-1:0]         pc_o,
   output logic [DATA_W-1:0]       status_o,
   output logic                    done_o
);

   localparam int PC_BYTES = PC_W / DATA_W;
   localparam int STEP_W   = $clog2(PC_BYTES + 1);

   // Elaboration-time parameter checks
   if ((PC_W % DATA_W) != 0 || PC_BYTES < 1) begin : g_bad_pc_w
      $error("PC_W must be a non-zero multiple of DATA_W");
   end
   if (BRK_BIT >= DATA_W || IDIS_BIT >= DATA_W || BRK_BIT == IDIS_BIT) begin : g_bad_flags
      $error("flag bit positions must be distinct and inside the status byte");
   end
   if (PAGE_SEL_EN && (PAGE0_HI == PAGE1_HI)) begin : g_bad_pages
      $error("the two stack pages must differ");
   end

   stk_op_e           op_q;
   logic [STEP_W-1:0] step;
   logic              accept;
   logic              push_stb;
   logic              pop_stb;
   logic [PTR_W-1:0]  sp;
   logic [PTR_W-1:0]  sp_up;
   logic [PAGE_W-1:0] page_hi;

   stkseq_ctrl #(
      .PC_BYTES (PC_BYTES),
      .STEP_W   (STEP_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .op_i       (stk_op_e'(op_i)),
      .accept_o   (accept),
      .op_o       (op_q),
      .step_o     (step),
      .push_stb_o (push_stb),
      .pop_stb_o  (pop_stb),
      .done_o     (done_o)
   );

   stkseq_ptr #(
      .PTR_W  (PTR_W),
      .SP_RST (SP_RST)
   ) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_stb_i (push_stb),
      .pop_stb_i  (pop_stb),
      .sp_o       (sp),
      .sp_up_o    (sp_up)
   );

   stkseq_data #(
      .DATA_W      (DATA_W),
      .PC_W        (PC_W),
      .PAGE_W      (PAGE_W),
      .STEP_W      (STEP_W),
      .BRK_BIT     (BRK_BIT),
      .IDIS_BIT    (IDIS_BIT),
      .PAGE_SEL_EN (PAGE_SEL_EN),
      .PAGE0_HI    (PAGE0_HI),
      .PAGE1_HI    (PAGE1_HI)
   ) u_data (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept_i   (accept),
      .op_acc_i   (stk_op_e'(op_i)),
      .pc_i       (pc_i),
      .status_i   (status_i),
      .brk_i      (brk_i),
      .page_sel_i (page_sel_i),
      .op_q_i     (op_q),
      .step_i     (step),
      .pop_stb_i  (pop_stb),
      .rdata_i    (mem_rdata_i),
      .wdata_o    (mem_wdata_o),
      .page_hi_o  (page_hi),
      .pc_o       (pc_o),
      .status_o   (status_o)
   );

   // Writes go to the pointer itself, reads to the pointer plus one
   assign mem_addr_o = {page_hi, (pop_stb ? sp_up : sp)};
   assign mem_we_o   = push_stb;
   assign mem_re_o   = pop_stb;
   assign sp_o       = sp;

endmodule

// File: rtl/stkseq_chk.sv
module stkseq_chk #(
   parameter int                PTR_W    = 8,
   parameter int                PAGE_W   = 8,
   parameter logic [PAGE_W-1:0] PAGE0_HI = 8'h00,
   parameter logic [PAGE_W-1:0] PAGE1_HI = 8'h01
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    mem_we_o,
   input logic                    mem_re_o,
   input logic                    done_o,
   input logic [PAGE_W+PTR_W-1:0] mem_addr_o,
   input logic [PTR_W-1:0]        sp_o
);

   logic [PAGE_W-1:0] addr_hi;
   assign addr_hi = mem_addr_o[PAGE_W+PTR_W-1 -: PAGE_W];

   a_r9_single_access: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we_o && mem_re_o));

   a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!mem_we_o && !mem_re_o));

   a_r2_write_at_sp: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (mem_addr_o[PTR_W-1:0] == sp_o));

   a_r2_post_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> (sp_o == $past(sp_o) - PTR_W'(1)));

   a_r4_read_above_sp: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re_o |-> (mem_addr_o[PTR_W-1:0] == sp_o + PTR_W'(1)));

   a_r4_pre_increment: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re_o |=> (sp_o == $past(sp_o) + PTR_W'(1)));

   a_r6_page_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o || mem_re_o) |-> (addr_hi == PAGE0_HI || addr_hi == PAGE1_HI));

   a_r10_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_re_o && (sp_o == '1)) |=> (sp_o == '0));

   a_r10_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && (sp_o == '0)) |=> (sp_o == '1));

endmodule

bind stack_sequencer stkseq_chk #(
   .PTR_W    (PTR_W),
   .PAGE_W   (PAGE_W),
   .PAGE0_HI (PAGE0_HI),
   .PAGE1_HI (PAGE1_HI)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_we_o   (mem_we_o),
   .mem_re_o   (mem_re_o),
   .done_o     (done_o),
   .mem_addr_o (mem_addr_o),
   .sp_o       (sp_o)
);

// File: tb/tb_stack_sequencer.sv
module tb_stack_sequencer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'd0;
   logic        brk = 1'b0;
   logic        pg = 1'b0;
   logic [15:0] pc_in = 16'h0;
   logic [7:0]  st_in = 8'h0;
   logic [7:0]  rdata;
   logic [15:0] addr;
   logic [7:0]  wdata;
   logic        we, re;
   logic [7:0]  sp;
   logic [15:0] pc_out;
   logic [7:0]  st_out;
   logic        done;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   stack_sequencer dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .brk_i(brk),
      .page_sel_i(pg), .pc_i(pc_in), .status_i(st_in), .mem_rdata_i(rdata),
      .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_we_o(we), .mem_re_o(re),
      .sp_o(sp), .pc_o(pc_out), .status_o(st_out), .done_o(done)
   );

   // Two-page stack memory, plus the bench's own model of it
   logic [7:0] tb_mem [0:511];
   logic [7:0] m_mem  [0:511];
   assign rdata = tb_mem[{addr[8], addr[7:0]}];
   always @(posedge clk) if (we) tb_mem[{addr[8], addr[7:0]}] <= wdata;

   typedef struct {
      logic        w;
      logic [15:0] a;
      logic [7:0]  d;
      string       req;
   } acc_t;
   acc_t exp_q[$];

   // Model state
   logic [7:0]  m_sp = 8'hFF;
   logic [15:0] m_pc = 16'h0;
   logic [7:0]  m_st = 8'h04;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Monitor: compare every access against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && (we || re)) begin
         checks++;
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R9 unexpected access actual=we%0b/%h expected=none", we, addr);
         end else begin
            acc_t e;
            e = exp_q.pop_front();
            if (e.w !== we || e.a !== addr || (e.w && e.d !== wdata)) begin
               failures++;
               $display("FAIL %s access actual=we%0b/%h/%h expected=we%0b/%h/%h",
                        e.req, we, addr, wdata, e.w, e.a, e.d);
            end
         end
      end
   end

   task automatic exp_wr(input logic p, input logic [7:0] lo, input logic [7:0] d, input string req);
      acc_t e;
      e.w = 1'b1; e.a = {7'h00, p, lo}; e.d = d; e.req = req;
      exp_q.push_back(e);
      m_mem[{p, lo}] = d;
   endtask

   task automatic exp_rd(input logic p, input logic [7:0] lo, input string req);
      acc_t e;
      e.w = 1'b0; e.a = {7'h00, p, lo}; e.d = 8'h00; e.req = req;
      exp_q.push_back(e);
   endtask

   // Driver: predict, start, then follow the sequence to done
   task automatic do_op(input logic [1:0] o, input logic [15:0] p_c, input logic [7:0] s_t,
                        input logic b, input logic p, input bit inject, input string req);
      logic [7:0]  s;
      logic [7:0]  sp_st;
      logic [15:0] epc;
      logic [7:0]  est;
      int          steps;
      int          cyc;
      s = m_sp; epc = m_pc; est = m_st; steps = 0;
      case (o)
         2'd0, 2'd1: begin
            exp_wr(p, s, p_c[15:8], req); s = s - 8'd1;
            exp_wr(p, s, p_c[7:0], req);  s = s - 8'd1;
            steps = 2;
            if (o == 2'd0) begin
               sp_st = s_t; sp_st[4] = b;          // R7 break bit in pushed status
               exp_wr(p, s, sp_st, "R7"); s = s - 8'd1;
               est = s_t | 8'h04;                  // R8
               steps = 3;
            end
         end
         2'd2: begin
            s = s + 8'd1; exp_rd(p, s, req); est = m_mem[{p, s}];
            s = s + 8'd1; exp_rd(p, s, req); epc[7:0] = m_mem[{p, s}];
            s = s + 8'd1; exp_rd(p, s, req); epc[15:8] = m_mem[{p, s}];
            steps = 3;
         end
         default: begin
            s = s + 8'd1; exp_rd(p, s, req); epc[7:0] = m_mem[{p, s}];
            s = s + 8'd1; exp_rd(p, s, req); epc[15:8] = m_mem[{p, s}];
            steps = 2;
         end
      endcase
      @(negedge clk);
      op = o; pc_in = p_c; st_in = s_t; brk = b; pg = p; start = 1'b1;
      @(negedge clk);
      cyc = 1;
      // R6: inputs scrambled after acceptance must not matter
      pc_in = ~p_c; st_in = ~s_t; brk = ~b; pg = ~p;
      if (o == 2'd0) chk("R8", "status one cycle after accept", {24'h0, st_out}, {24'h0, est});
      if (inject) begin
         start = 1'b1; op = 2'd3;                  // R11 request while busy
      end else begin
         start = 1'b0;
      end
      while (!done && cyc < 16) begin
         @(negedge clk);
         cyc++;
         start = 1'b0;
      end
      chk("R9", "done latency", cyc, steps + 1);
      chk(req, "sp", {24'h0, sp}, {24'h0, s});
      chk(req, "pc_o", {16'h0, pc_out}, {16'h0, epc});
      chk(req, "status_o", {24'h0, st_out}, {24'h0, est});
      @(negedge clk);
      chk("R9", "done single pulse", {31'h0, done}, 32'h0);
      chk(inject ? "R11" : req, "pending accesses", exp_q.size(), 0);
      m_sp = s; m_pc = epc; m_st = est;
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 512; i++) begin
         tb_mem[i] = 8'(i ^ 8'h5A);
         m_mem[i]  = 8'(i ^ 8'h5A);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "sp", {24'h0, sp}, 32'hFF);
      chk("R1", "status_o", {24'h0, st_out}, 32'h04);
      chk("R1", "pc_o", {16'h0, pc_out}, 32'h0);
      chk("R1", "done", {31'h0, done}, 32'h0);
      chk("R1", "access", {30'h0, we, re}, 32'h0);

      do_op(2'd0, 16'h1234, 8'hD3, 1'b0, 1'b0, 1'b0, "R2");   // hardware entry, bit 4 cleared
      do_op(2'd0, 16'hABCD, 8'h20, 1'b1, 1'b1, 1'b0, "R6");   // break entry on page 1
      do_op(2'd1, 16'h5678, 8'hFF, 1'b1, 1'b0, 1'b0, "R3");   // call: two bytes only
      do_op(2'd3, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, "R5");   // return from call
      do_op(2'd2, 16'h0000, 8'h00, 1'b0, 1'b1, 1'b0, "R4");   // return from break
      do_op(2'd0, 16'h9A0F, 8'h81, 1'b0, 1'b0, 1'b1, "R11");  // start ignored while busy
      do_op(2'd2, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, "R4");
      do_op(2'd3, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, "R5");   // sp FC -> FE
      do_op(2'd3, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, "R10");  // reads FF then 00
      chk("R10", "sp wrapped to 00", {24'h0, sp}, 32'h0);
      do_op(2'd1, 16'hC3E1, 8'h00, 1'b0, 1'b0, 1'b0, "R10");  // writes 00 then FF
      do_op(2'd3, 16'h0000, 8'h00, 1'b0, 1'b0, 1'b0, "R10");
      chk("R10", "pc round trip across wrap", {16'h0, pc_out}, 32'hC3E1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule